// File: doc/BRIEF.md
# Shaper Rate Parameter Calculator

This block turns a requested bandwidth in Mbps into the three fields that program a tick-based token-bucket shaper: an 8-bit mantissa, an exponent that scales the rate up and an exponent that scales it down. The programmed rate equals mantissa × 2^up × 8000 / (tick × 2^down), where the tick length depends on which of four shaper levels (priority, group, port, queue set) is being set up. Their ticks are 1536, 192, 48 and 1536 in that order.

A caller pulses `start_i` with a rate and a level. The block first derives the rate that mantissa 126 gives with both exponents at zero. It then searches one exponent step at a time, up or down, until it brackets the request, and finally derives a rounded mantissa. Every quotient comes from one shared serial divider. The result appears with a one-cycle `done_o` pulse. `busy_o` is high for the whole search.

Top module: `shaper_rate_calc`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and mant_o, up_o and dn_o are zero.
- R2: A level of 4 or higher is rejected: done_o pulses with err_o high and all three fields zero.
- R3: A rate above 100000 Mbps is rejected in the same way as R2.
- R4: When the request equals the reference rate ref = (1008000 + tick/2 − 1) / tick (integer division), the result is mantissa 126 with both exponents zero.
- R5: When the request is below ref, the down exponent s is the smallest s ≥ 1 for which 1008000 / (tick × 2^s) falls below the request. The mantissa is then (rate × tick × 2^s + 4000) / 8000, and the up exponent is zero.
- R6: When the request is above ref, u is raised until (1008000 × 2^u + tick/2) / tick is no longer below the request. If that value is not equal to the request, the result is up exponent u−1 and mantissa (rate × tick + D/2) / D, with D = 8000 × 2^(u−1). The down exponent is zero.
- R7: When the upward search lands exactly on the request, the result is mantissa 126 with the up exponent u at which the search stopped.
- R8: A rate of 0 at a valid level returns mantissa 0, both exponents 0 and err_o low.
- R9: busy_o goes high in the cycle after a start is accepted and stays high until the result is ready. A start while busy_o is high is ignored.
- R10: done_o is high for exactly one cycle per accepted request. The fields and err_o keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when busy_o is low |
| level_i | input | 3 | Shaper level (0 to 3 valid) |
| rate_i | input | 17 | Requested rate in Mbps |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Request rejected |
| mant_o | output | 8 | Rate mantissa, saturated at 255 |
| up_o | output | 4 | Up-shift exponent |
| dn_o | output | 4 | Down-shift exponent |

## Verification
Every level code from 0 to 7 is swept with rates chosen to reach each branch of the search. Rate 0 separates the zero case from the downward walk. Rates 1 and 10 drive the down exponent to its deepest values on the slow-tick levels. Rates 656, 5250 and 21000 hit the reference exactly on the level that owns them, and the same rates land in one of the two walks on the other levels. Rate 42000 on the port level ends the upward walk on an exact hit. Rate 100000 pushes the up exponent as far as it goes, and rate 100001 and level codes 4 to 7 take the two reject paths. A second start issued mid-search shows whether a busy block ignores it.

// File: rtl/srate_pkg.sv
package srate_pkg;
    localparam int unsigned NUM_LEVELS = 4;
    localparam int unsigned REF_NUM    = 1008000; // 126 * 8 * 1000
    localparam int unsigned CLK_DIV    = 8000;
    localparam int unsigned REF_MANT   = 126;

    typedef enum logic [2:0] {
        PH_IDLE, PH_REF, PH_DOWN, PH_UP, PH_MANT, PH_FIN
    } phase_e;
endpackage

// File: rtl/srate_tick_sel.sv
module srate_tick_sel #(
    parameter int LVL_W = 3,
    parameter int DW    = 32
) (
    input  logic [LVL_W-1:0] level_i,
    output logic [DW-1:0]    tick_o
);
    always_comb begin
        case (level_i)
            LVL_W'(0): tick_o = DW'(1536);
            LVL_W'(1): tick_o = DW'(192);
            LVL_W'(2): tick_o = DW'(48);
            LVL_W'(3): tick_o = DW'(1536);
            default:   tick_o = '0;
        endcase
    end
endmodule

// File: rtl/srate_divider.sv
module srate_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         vld_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        logic          run;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_t;

    div_t c_q, c_d;
    logic [W:0] trial;

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        trial   = {c_q.rem, c_q.quo[W-1]};
        if (go_i) begin
            c_d.run = 1'b1;
            c_d.cnt = CW'(W);
            c_d.rem = '0;
            c_d.quo = num_i;
            c_d.den = den_i;
        end else if (c_q.run) begin
            if (trial >= {1'b0, c_q.den}) begin
                c_d.rem = W'(trial - {1'b0, c_q.den});
                c_d.quo = {c_q.quo[W-2:0], 1'b1};
            end else begin
                c_d.rem = trial[W-1:0];
                c_d.quo = {c_q.quo[W-2:0], 1'b0};
            end
            c_d.cnt = c_q.cnt - 1'b1;
            if (c_q.cnt == CW'(1)) begin
                c_d.run = 1'b0;
                c_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign vld_o = c_q.vld;
    assign quo_o = c_q.quo;

    // Divider serves the searches of R5 and R6; a zero divisor would break them.
    assert_div_den_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (den_i != '0));
    assert_div_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
endmodule

// File: rtl/shaper_rate_calc.sv
module shaper_rate_calc
    import srate_pkg::*;
#(
    parameter int LVL_W    = 3,
    parameter int RATE_W   = 17,
    parameter int MANT_W   = 8,
    parameter int EXP_W    = 4,
    parameter int DW       = 32,
    parameter int RATE_MAX = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]  up_o,
    output logic [EXP_W-1:0]  dn_o
);
    localparam logic [DW-1:0] MANT_MAX = DW'((1 << MANT_W) - 1);

    typedef struct packed {
        phase_e            ph;
        logic [DW-1:0]     rate;
        logic [DW-1:0]     tick;
        logic [EXP_W-1:0]  up;
        logic [EXP_W-1:0]  dn;
        logic [MANT_W-1:0] mant;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t c_q, c_d;

    logic          div_go, div_vld;
    logic [DW-1:0] div_num, div_den, div_q;
    logic [DW-1:0] tick_in, prod, dstep;
    logic [EXP_W-1:0] e_next, e_prev;
    logic          bad_req;

    srate_tick_sel #(.LVL_W(LVL_W), .DW(DW)) u_tick (
        .level_i (level_i),
        .tick_o  (tick_in)
    );

    srate_divider #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (div_num),
        .den_i (div_den),
        .vld_o (div_vld),
        .quo_o (div_q)
    );

    always_comb begin
        c_d     = c_q;
        c_d.done = 1'b0;
        div_go  = 1'b0;
        div_num = '0;
        div_den = DW'(1);
        bad_req = (DW'(level_i) >= DW'(NUM_LEVELS)) || (DW'(rate_i) > DW'(RATE_MAX));
        prod    = c_q.rate * c_q.tick;
        e_next  = '0;
        e_prev  = '0;
        dstep   = '0;
        case (c_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    c_d.rate = DW'(rate_i);
                    c_d.tick = tick_in;
                    c_d.up   = '0;
                    c_d.dn   = '0;
                    c_d.mant = '0;
                    c_d.err  = 1'b0;
                    if (bad_req) begin
                        c_d.err = 1'b1;
                        c_d.ph  = PH_FIN;
                    end else if (rate_i == '0) begin
                        c_d.ph  = PH_FIN;
                    end else begin
                        div_go  = 1'b1;
                        div_num = DW'(REF_NUM) + (tick_in >> 1) - DW'(1);
                        div_den = tick_in;
                        c_d.ph  = PH_REF;
                    end
                end
            end
            PH_REF: begin
                if (div_vld) begin
                    if (div_q == c_q.rate) begin
                        c_d.mant = MANT_W'(REF_MANT);
                        c_d.ph   = PH_FIN;
                    end else if (div_q > c_q.rate) begin
                        c_d.dn  = EXP_W'(1);
                        div_go  = 1'b1;
                        div_num = DW'(REF_NUM);
                        div_den = c_q.tick << 1;
                        c_d.ph  = PH_DOWN;
                    end else begin
                        c_d.up  = EXP_W'(1);
                        div_go  = 1'b1;
                        div_num = (DW'(REF_NUM) << 1) + (c_q.tick >> 1);
                        div_den = c_q.tick;
                        c_d.ph  = PH_UP;
                    end
                end
            end
            PH_DOWN: begin
                if (div_vld) begin
                    div_go = 1'b1;
                    if (div_q >= c_q.rate) begin
                        e_next  = c_q.dn + 1'b1;
                        c_d.dn  = e_next;
                        div_num = DW'(REF_NUM);
                        div_den = c_q.tick << e_next;
                    end else begin
                        div_num = (prod << c_q.dn) + DW'(CLK_DIV / 2);
                        div_den = DW'(CLK_DIV);
                        c_d.ph  = PH_MANT;
                    end
                end
            end
            PH_UP: begin
                if (div_vld) begin
                    if (div_q < c_q.rate) begin
                        e_next  = c_q.up + 1'b1;
                        c_d.up  = e_next;
                        div_go  = 1'b1;
                        div_num = (DW'(REF_NUM) << e_next) + (c_q.tick >> 1);
                        div_den = c_q.tick;
                    end else if (div_q == c_q.rate) begin
                        c_d.mant = MANT_W'(REF_MANT);
                        c_d.ph   = PH_FIN;
                    end else begin
                        e_prev  = c_q.up - 1'b1;
                        dstep   = DW'(CLK_DIV) << e_prev;
                        c_d.up  = e_prev;
                        div_go  = 1'b1;
                        div_num = prod + (dstep >> 1);
                        div_den = dstep;
                        c_d.ph  = PH_MANT;
                    end
                end
            end
            PH_MANT: begin
                if (div_vld) begin
                    c_d.mant = (div_q > MANT_MAX) ? '1 : div_q[MANT_W-1:0];
                    c_d.ph   = PH_FIN;
                end
            end
            PH_FIN: begin
                c_d.done = 1'b1;
                c_d.ph   = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.ph <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.ph != PH_IDLE);
    assign done_o = c_q.done;
    assign err_o  = c_q.err;
    assign mant_o = c_q.mant;
    assign up_o   = c_q.up;
    assign dn_o   = c_q.dn;

    assert_err_fields_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (mant_o == '0 && up_o == '0 && dn_o == '0));
    assert_exp_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (up_o == '0 || dn_o == '0));
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && !$past(start_i)) |->
        ($stable(mant_o) && $stable(up_o) && $stable(dn_o) && $stable(err_o)));
endmodule

// File: tb/shaper_rate_calc_test.sv
module shaper_rate_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  level_i = '0;
    logic [16:0] rate_i = '0;
    logic        busy_o, done_o, err_o;
    logic [7:0]  mant_o;
    logic [3:0]  up_o, dn_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    shaper_rate_calc uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .rate_i(rate_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mant_o(mant_o), .up_o(up_o), .dn_o(dn_o)
    );

    function automatic void model(input int lvl, input longint r,
                                  output bit e, output int m, output int u,
                                  output int s, output string tag);
        longint t, rf, d;
        e = 0; m = 0; u = 0; s = 0;
        case (lvl)
            0: t = 1536; 1: t = 192; 2: t = 48; 3: t = 1536; default: t = 0;
        endcase
        if (lvl >= 4) begin e = 1; tag = "R2"; return; end
        if (r > 100000) begin e = 1; tag = "R3"; return; end
        if (r == 0) begin tag = "R8"; return; end
        rf = (1008000 + t / 2 - 1) / t;
        if (rf == r) begin m = 126; tag = "R4"; end
        else if (rf > r) begin
            while (rf >= r) begin s++; rf = 1008000 / (t * (longint'(1) << s)); end
            m = int'((r * t * (longint'(1) << s) + 4000) / 8000);
            tag = "R5";
        end else begin
            while (rf < r) begin u++; rf = (1008000 * (longint'(1) << u) + t / 2) / t; end
            if (rf == r) begin m = 126; tag = "R7"; end
            else begin
                u--;
                d = 8000 * (longint'(1) << u);
                m = int'((r * t + d / 2) / d);
                tag = "R6";
            end
        end
        if (m > 255) m = 255;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        if (!done_o) check(tag, "done timeout", 0, 1);
    endtask

    task automatic run_one(input int lvl, input int r);
        bit e; int m, u, s; string tag;
        model(lvl, longint'(r), e, m, u, s, tag);
        @(negedge clk);
        start_i = 1'b1; level_i = 3'(lvl); rate_i = 17'(r);
        @(negedge clk);
        start_i = 1'b0;
        wait_done(tag);
        check(tag, $sformatf("err L%0d r%0d", lvl, r), int'(err_o), int'(e));
        check(tag, $sformatf("mant L%0d r%0d", lvl, r), int'(mant_o), m);
        check(tag, $sformatf("up L%0d r%0d", lvl, r), int'(up_o), u);
        check(tag, $sformatf("dn L%0d r%0d", lvl, r), int'(dn_o), s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        int rates[14] = '{0, 1, 10, 656, 1000, 5250, 21000, 42000, 25000,
                          100000, 100001, 333, 7777, 65000};
        bit e; int m, u, s; string tag;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "err", int'(err_o), 0);
        check("R1", "fields", int'({mant_o, up_o, dn_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after release", int'(busy_o), 0);

        for (int lv = 0; lv < 8; lv++)
            for (int k = 0; k < 14; k++)
                run_one(lv, rates[k]);

        // R9: busy and start ignored while busy
        model(1, 1000, e, m, u, s, tag);
        @(negedge clk);
        start_i = 1'b1; level_i = 3'd1; rate_i = 17'd1000;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "busy after start", int'(busy_o), 1);
        repeat (5) @(negedge clk);
        start_i = 1'b1; level_i = 3'd0; rate_i = 17'd5;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "still busy", int'(busy_o), 1);
        wait_done("R9");
        check("R9", "busy low at done", int'(busy_o), 0);
        check("R9", "mant of first request", int'(mant_o), m);
        check("R9", "dn of first request", int'(dn_o), s);
        check("R9", "up of first request", int'(up_o), u);
        // R10: single-cycle done, held fields
        @(negedge clk);
        check("R10", "done dropped", int'(done_o), 0);
        repeat (4) @(negedge clk);
        check("R10", "done stays low", int'(done_o), 0);
        check("R10", "mant held", int'(mant_o), m);
        check("R10", "dn held", int'(dn_o), s);
        check("R10", "busy idle", int'(busy_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule